// File: doc/BRIEF.md
# Byte Program Pulse-and-Verify Sequencer

This block sits on the host side of a parallel flash bus and writes one byte into the flash through a closed loop. A request brings in an address and a data byte. The sequencer turns on the high-voltage programming supply and starts the first attempt. Each attempt writes the program-setup code, then the address and the data. A program pulse of fixed length follows, and its length is counted in clocks. Next the sequencer writes the verify command, waits a short recovery time and reads the byte back.

If the readback matches the data, the loop ends with success. If it does not match, a new attempt starts. After the last allowed attempt the byte is declared failed. In both cases two reset-code writes return the flash to read mode. The supply is then switched off and a one-cycle done or fail pulse ends the operation.

Each bus access is a single-cycle strobe. On a read, the flash returns the data in the same cycle as the strobe.

Top module: `byte_prog_sequencer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, busy, done, fail, vpp_en, bus_wr and bus_rd are all low.
- R2: In the idle state, a cycle with req_valid high is accepted. From the next cycle, busy and vpp_en are high. busy stays high up to and including the cycle in which done or fail pulses, and it is low in the following cycle.
- R3: An attempt is two bus writes on consecutive cycles, both to the request address: first the setup code 0x40, then the request data.
- R4: Between the data write of an attempt and its verify write of 0xC0 there are exactly PULSE_US*CLK_MHZ bus-idle cycles. This is the program pulse.
- R5: Between the verify write and the read strobe there are exactly RECOVER_CYCLES bus-idle cycles.
- R6: If the byte read back equals the request data, the loop ends with done. The number of pulses equals the number of the attempt whose readback matched.
- R7: No request gets more than MAX_PULSES pulses. If the readback after pulse MAX_PULSES still differs from the request data, the request ends with fail.
- R8: After the final read come exactly two consecutive writes of 0xFF. The cycle after the second of these carries a single done or fail pulse, and vpp_en is already low in that cycle.
- R9: vpp_en is high in every cycle that has a bus read or bus write.
- R10: While busy is high, req_valid has no effect. The address and data of the operation in progress are unchanged on the bus, and no extra operation follows.
- R11: The attempt count restarts for every request. A request that follows a failed one again gets up to MAX_PULSES pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Byte address to program |
| req_data | input | DATA_W | Byte value to program |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: the byte verified |
| fail | output | 1 | One-cycle pulse: the attempt limit was reached |
| vpp_en | output | 1 | Enable for the programming supply |
| bus_wr | output | 1 | Single-cycle bus write strobe |
| bus_rd | output | 1 | Single-cycle bus read strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Read data, valid in the cycle of bus_rd |

## Verification
The bench builds the block with CLK_MHZ=2 and PULSE_US=10, which gives a 20-cycle pulse, with RECOVER_CYCLES=3 and with the default limit of 25 pulses. At these values a full 25-attempt failure takes only a few hundred cycles. This puts the limit boundary in reach: a byte that verifies on pulse 25, and bytes that verify on pulse 26 or never. Many random requests, some with intruding req_valid traffic, also fit in the run. Data values equal to the command codes are tested, so that a command cannot be mistaken for data.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_PULSE,
        ST_VCMD,
        ST_RECOVER,
        ST_READ,
        ST_EXIT1,
        ST_EXIT2,
        ST_REPORT
    } seq_state_e;
endpackage

// File: rtl/bpp_timer.sv
module bpp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bpp_attempts.sv
module bpp_attempts #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)    cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit = (cnt_q >= CW'(MAX_PULSES));
endmodule

// File: rtl/byte_prog_sequencer.sv
module byte_prog_sequencer
    import bpp_pkg::*;
#(
    parameter int ADDR_W         = 17,
    parameter int DATA_W         = 8,
    parameter int CLK_MHZ        = 200,
    parameter int PULSE_US       = 10,
    parameter int RECOVER_CYCLES = 4,
    parameter int MAX_PULSES     = 25,
    parameter logic [DATA_W-1:0] CMD_SETUP  = 'h40,
    parameter logic [DATA_W-1:0] CMD_VERIFY = 'hC0,
    parameter logic [DATA_W-1:0] CMD_RESET  = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              vpp_en,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int PULSE_CYCLES = CLK_MHZ * PULSE_US;
    localparam int TMR_MAX = (PULSE_CYCLES > RECOVER_CYCLES) ? PULSE_CYCLES : RECOVER_CYCLES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              passed;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             att_clr;
    logic             att_inc;
    logic             att_at_limit;

    bpp_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    bpp_attempts #(.MAX_PULSES(MAX_PULSES)) u_attempts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (att_clr),
        .inc      (att_inc),
        .at_limit (att_at_limit)
    );

    // next-state logic
    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        att_clr  = 1'b0;
        att_inc  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr   = req_addr;
                    r_d.data   = req_data;
                    r_d.passed = 1'b0;
                    att_clr    = 1'b1;
                    r_d.state  = ST_SETUP;
                end
            end
            ST_SETUP: r_d.state = ST_DATA;
            ST_DATA: begin
                att_inc   = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(PULSE_CYCLES - 1);
                r_d.state = ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_expired) r_d.state = ST_VCMD;
            end
            ST_VCMD: begin
                tmr_load  = 1'b1;
                tmr_val   = TMR_W'(RECOVER_CYCLES - 1);
                r_d.state = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (tmr_expired) r_d.state = ST_READ;
            end
            ST_READ: begin
                if (bus_rdata == r_q.data) begin
                    r_d.passed = 1'b1;
                    r_d.state  = ST_EXIT1;
                end else if (att_at_limit) begin
                    r_d.passed = 1'b0;
                    r_d.state  = ST_EXIT1;
                end else begin
                    r_d.state  = ST_SETUP;
                end
            end
            ST_EXIT1:  r_d.state = ST_EXIT2;
            ST_EXIT2:  r_d.state = ST_REPORT;
            ST_REPORT: r_d.state = ST_IDLE;
            default:   r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, addr: '0, data: '0, passed: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // output decode from the registered state
    always_comb begin
        bus_wr    = 1'b0;
        bus_wdata = '0;
        unique case (r_q.state)
            ST_SETUP: begin bus_wr = 1'b1; bus_wdata = CMD_SETUP;  end
            ST_DATA:  begin bus_wr = 1'b1; bus_wdata = r_q.data;   end
            ST_VCMD:  begin bus_wr = 1'b1; bus_wdata = CMD_VERIFY; end
            ST_EXIT1, ST_EXIT2: begin bus_wr = 1'b1; bus_wdata = CMD_RESET; end
            default: ;
        endcase
    end

    assign bus_rd   = (r_q.state == ST_READ);
    assign bus_addr = r_q.addr;
    assign busy     = (r_q.state != ST_IDLE);
    assign vpp_en   = (r_q.state != ST_IDLE) && (r_q.state != ST_REPORT);
    assign done     = (r_q.state == ST_REPORT) && r_q.passed;
    assign fail     = (r_q.state == ST_REPORT) && !r_q.passed;
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
    parameter int ADDR_W     = 17,
    parameter int MAX_PULSES = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              vpp_en,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr
);
    localparam int RW = $clog2(MAX_PULSES + 2);

    logic [RW-1:0] reads_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy)       reads_q <= '0;
        else if (bus_rd && reads_q != '1) reads_q <= reads_q + 1'b1;
    end

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fail) |=> busy);

    assert_idle_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |=> !busy);

    assert_vpp_on_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> vpp_en);

    assert_read_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reads_q <= RW'(MAX_PULSES));

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !fail) |=> $stable(bus_addr));
endmodule

bind byte_prog_sequencer bpp_checker #(
    .ADDR_W     (ADDR_W),
    .MAX_PULSES (MAX_PULSES)
) u_bpp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fail     (fail),
    .vpp_en   (vpp_en),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr)
);

// File: tb/byte_prog_sequencer_bench.sv
module byte_prog_sequencer_bench;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int CLK_MHZ = 2;
    localparam int PULSE_US = 10;
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int REC_CYC = 3;
    localparam int MAXP = 25;

    localparam int PH_SETUP = 0, PH_DATA = 1, PH_VCMD = 2, PH_READ = 3,
                   PH_AFTER = 4, PH_FF2 = 5, PH_END = 6;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic busy, done, fail, vpp_en, bus_wr, bus_rd;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;

    always #2.5 clk = ~clk;

    byte_prog_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US),
        .RECOVER_CYCLES(REC_CYC), .MAX_PULSES(MAXP)
    ) u_byte_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .fail(fail), .vpp_en(vpp_en),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // flash model and bus monitor state
    logic [ADDR_W-1:0] exp_addr;
    logic [DATA_W-1:0] exp_data;
    logic [DATA_W-1:0] bad_mask;
    int good_after;
    int phase, gap, pulses, reads;
    int err_seq, err_pulse, err_rec, err_vpp, ends;
    int end_phase;
    logic end_vpp, end_done, end_fail;
    logic seen_end;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        return (k <= MAXP) ? k : MAXP;
    endfunction

    function automatic bit exp_pass(input int k);
        return k <= MAXP;
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (bus_wr || bus_rd) begin
                if (!vpp_en) err_vpp++;
                if (bus_addr != exp_addr) err_seq++;
            end
            if (bus_wr) begin
                case (phase)
                    PH_SETUP: if (bus_wdata == 8'h40) phase = PH_DATA; else err_seq++;
                    PH_DATA: begin
                        if (bus_wdata == exp_data) begin
                            pulses++; gap = 0; phase = PH_VCMD;
                        end else err_seq++;
                    end
                    PH_VCMD: begin
                        if (bus_wdata != 8'hC0) err_seq++;
                        if (gap != PULSE_CYC) err_pulse++;
                        gap = 0; phase = PH_READ;
                    end
                    PH_AFTER: begin
                        if (bus_wdata == 8'h40) phase = PH_DATA;
                        else if (bus_wdata == 8'hFF) phase = PH_FF2;
                        else err_seq++;
                    end
                    PH_FF2: if (bus_wdata == 8'hFF) phase = PH_END; else err_seq++;
                    default: err_seq++;
                endcase
            end else if (bus_rd) begin
                if (phase != PH_READ) err_seq++;
                if (gap != REC_CYC) err_rec++;
                reads++;
                phase = PH_AFTER;
            end else begin
                gap++;
            end
            if (done || fail) begin
                ends++;
                seen_end = 1;
                end_phase = phase;
                end_vpp = vpp_en;
                end_done = done;
                end_fail = fail;
            end
            bus_rdata = (pulses >= good_after) ? exp_data : (exp_data ^ bad_mask);
        end
    end

    task automatic run_one(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input int k, input bit intrude, input string tag);
        int t;
        @(negedge clk); #1;
        exp_addr = a; exp_data = d; good_after = k;
        bad_mask = DATA_W'($urandom_range(1, 255));
        phase = PH_SETUP; gap = 0; pulses = 0; reads = 0;
        err_seq = 0; err_pulse = 0; err_rec = 0; err_vpp = 0; ends = 0;
        seen_end = 0;
        req_addr = a; req_data = d; req_valid = 1;
        @(negedge clk); #1;
        req_valid = 0;
        check(busy && vpp_en, {"R2 accept ", tag}, {busy, vpp_en}, 3);
        t = 0;
        while (!seen_end && t < 2000) begin
            if (intrude) begin
                req_valid = 1'($urandom_range(0, 1));
                req_addr = ADDR_W'($urandom());
                req_data = DATA_W'($urandom());
            end
            @(negedge clk); #1;
            t++;
        end
        req_valid = 0;
        check(seen_end, {"R2 end seen ", tag}, seen_end, 1);
        check(end_done == exp_pass(k) && end_fail == !exp_pass(k),
              {"R6 R7 outcome ", tag}, {end_done, end_fail}, exp_pass(k) ? 2 : 1);
        check(pulses == exp_pulses(k), {"R6 R7 R11 pulse count ", tag}, pulses, exp_pulses(k));
        check(err_seq == 0, {"R3 R10 bus sequence ", tag}, err_seq, 0);
        check(err_pulse == 0, {"R4 pulse width ", tag}, err_pulse, 0);
        check(err_rec == 0, {"R5 recovery gap ", tag}, err_rec, 0);
        check(err_vpp == 0, {"R9 supply on bus ", tag}, err_vpp, 0);
        check(end_phase == PH_END && !end_vpp, {"R8 exit writes ", tag}, end_phase, PH_END);
        // two idle cycles: busy low, no second operation
        @(negedge clk); #1;
        check(!busy && !vpp_en, {"R2 idle after ", tag}, busy, 0);
        @(negedge clk); #1;
        check(ends == 1 && !busy, {"R10 single report ", tag}, ends, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        req_valid = 1;
        #1;
        check(!busy && !done && !fail && !vpp_en && !bus_wr && !bus_rd, "R1 in reset", busy, 0);
        req_valid = 0;
        @(negedge clk); #1;
        rst_n = 1;
        @(negedge clk); #1;
        check(!busy && !done && !fail && !vpp_en && !bus_wr && !bus_rd, "R1 after reset", busy, 0);

        run_one(17'h00010, 8'hA5, 1, 0, "first pulse R6");
        run_one(17'h1FFFF, 8'h3C, 2, 0, "second pulse R6");
        run_one(17'h00000, 8'h40, 25, 0, "last allowed R7");
        run_one(17'h12345, 8'hC0, 26, 0, "one over R7");
        run_one(17'h0ABCD, 8'hFF, 1000, 1, "never R11");
        run_one(17'h0ABCE, 8'h00, 3, 1, "after fail R11");
        for (int i = 0; i < 20; i++) begin
            run_one(ADDR_W'($urandom()), DATA_W'($urandom()), $urandom_range(1, 30),
                    1'($urandom_range(0, 1)), "random");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule